// File: doc/BRIEF.md
# Host Watchdog Control Register

This block holds an 8-bit control register that a host writes through a plain write port: a strobe and a data byte. A watchdog timer is part of the register. A 2-bit field in the register selects the watchdog period or turns the watchdog off. A self-clearing kick bit restarts the count. Time is measured in ticks of an external one-second strobe, which the block counts on the clock edges where the strobe is high. Because the clock and the time base are separate, a bench can set the tick rate freely.

When a host stops servicing the block, the count reaches the selected period. The block then raises a one-cycle timeout pulse and returns every bit of the register to its power-on value. A synchronous register-reset request has the same effect on the register and on the count, but it does not raise the pulse. The other register bits (termination enable, safety-timer enable, safety-timer select, slow-down enable) are only stored here. Other logic uses them.

Top module: `host_wdt_reg`

## Requirements
- R1: After `rst`, `ctrl_q` is 8'h9D. The layout from MSB to LSB is: bit 7 termination enable = 1, bit 6 kick = 0, bits 5:4 timeout select = 1, bit 3 safety-timer enable = 1, bits 2:1 safety-timer select = 2, bit 0 slow-down enable = 1. `wdt_expired` is 0.
- R2: Timeout select value k (1, 2 or 3) sets a period of `TICK_UNIT << (k-1)` ticks. The count restarts after each restart event. On the edge that counts the period-th tick, `wdt_expired` goes high for the following cycle.
- R3: A clock edge counts toward the period only when `tick_1s` is high. Cycles with `tick_1s` low do not advance the count.
- R4: While timeout select is 0, the count is held at zero and `wdt_expired` never goes high, however many ticks arrive.
- R5: A write whose bits 5:4 differ from the held timeout select restarts the count. A write that repeats the held value does not restart it.
- R6: A write with bit 6 set restarts the count. `ctrl_q[6]` reads 1 for exactly the cycle after that write and then returns to 0 by itself.
- R7: On expiry, `wdt_expired` is high for exactly one cycle. In that same cycle `ctrl_q` reads 8'h9D. The count starts again from zero.
- R8: A cycle with `reg_rst` high loads 8'h9D into `ctrl_q` and clears the count. It overrides a write in the same cycle and never raises `wdt_expired`.
- R9: When a restart write (kick set or select changed) arrives in the same cycle as the expiring tick, the write wins: there is no pulse and the written value is stored. A write without a restart in that same cycle is lost, and the register takes its defaults.
- R10: A write stores all eight data bits into `ctrl_q` on the next edge, apart from the later self-clearing of bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| reg_rst | input | 1 | Synchronous register-reset request |
| tick_1s | input | 1 | One-second time-base strobe |
| ctrl_q | output | 8 | Register contents |
| wdt_expired | output | 1 | One-cycle timeout pulse |

## Verification
The hardest case to reach from the ports is the collision in R9: a write must land on the exact cycle that carries the expiring tick. The bench first restarts the count with a kick. It then counts the period minus one ticks, checking that no pulse occurs. It then drives the last tick together with the write in the same cycle, once with a kick and once with a plain rewrite of the held value. The periods in the bench are small (3, 6 and 12 ticks), so every select value is swept against tick gaps of zero to two idle cycles. Expiry cycles are computed from the tick count alone.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W = 8;

  // bit positions decoded by the counter and the register
  localparam int KICK_BIT = 6;
  localparam int SEL_LO   = 4;
  localparam int SEL_W    = 2;

  // power-on contents: term=1 kick=0 sel=1 safe_en=1 safe_sel=2 slow=1
  localparam logic [REG_W-1:0] CTRL_DEFAULT = 8'h9D;

  function automatic logic [SEL_W-1:0] sel_of(input logic [REG_W-1:0] r);
    return r[SEL_LO +: SEL_W];
  endfunction
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_def,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || load_def) begin
      q <= CTRL_DEFAULT;
    end else if (wr_en) begin
      q <= wr_data;
    end else begin
      q[KICK_BIT] <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter
  import wdt_pkg::*;
#(
  parameter int TICK_UNIT = 40
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  localparam int MAX_PERIOD = TICK_UNIT << ((1 << SEL_W) - 2);
  localparam int CW         = $clog2(MAX_PERIOD + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          active;

  assign active = (sel != '0);

  always_comb begin
    last = '0;
    for (int k = 1; k < (1 << SEL_W); k++) begin
      if (sel == SEL_W'(k)) last = CW'((TICK_UNIT << (k - 1)) - 1);
    end
  end

  assign hit = tick && active && (cnt == last);

  always_ff @(posedge clk) begin
    if (clear || !active) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/host_wdt_reg.sv
module host_wdt_reg
  import wdt_pkg::*;
#(
  parameter int TICK_UNIT = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       reg_rst,
  input  logic       tick_1s,
  output logic [7:0] ctrl_q,
  output logic       wdt_expired
);
  logic restart_req;
  logic hit;
  logic expire_now;
  logic cnt_clear;

  assign restart_req = wr_en &&
                       (wr_data[KICK_BIT] || (sel_of(wr_data) != sel_of(ctrl_q)));
  assign expire_now  = hit && !restart_req && !reg_rst;
  assign cnt_clear   = rst || reg_rst || restart_req || expire_now;

  wdt_ctrl_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .load_def (reg_rst || expire_now),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .q        (ctrl_q)
  );

  wdt_tick_counter #(.TICK_UNIT(TICK_UNIT)) u_cnt (
    .clk   (clk),
    .clear (cnt_clear),
    .tick  (tick_1s),
    .sel   (sel_of(ctrl_q)),
    .hit   (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) wdt_expired <= 1'b0;
    else     wdt_expired <= expire_now;
  end
endmodule

// File: rtl/host_wdt_reg_chk.sv
module host_wdt_reg_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       reg_rst,
  input logic       tick_1s,
  input logic [7:0] ctrl_q,
  input logic       wdt_expired
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wdt_expired |=> !wdt_expired); // R7
  AST_EXPIRY_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    wdt_expired |-> ctrl_q == 8'h9D); // R7
  AST_EXPIRY_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    wdt_expired |-> $past(tick_1s)); // R3
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
    wdt_expired |-> $past(ctrl_q[5:4]) != 2'd0); // R4
  AST_REGRST_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    reg_rst |=> (ctrl_q == 8'h9D) && !wdt_expired); // R8
  AST_KICK_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[6] && !wr_en && !reg_rst) |=> !ctrl_q[6]); // R6
  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !reg_rst && (wr_data[6] || wr_data[5:4] != ctrl_q[5:4]))
      |=> ctrl_q == $past(wr_data)); // R9
endmodule

bind host_wdt_reg host_wdt_reg_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .reg_rst     (reg_rst),
  .tick_1s     (tick_1s),
  .ctrl_q      (ctrl_q),
  .wdt_expired (wdt_expired)
);

// File: tb/host_wdt_reg_test.sv
`timescale 1ns/1ps
module host_wdt_reg_test;
  localparam int UNIT = 3;
  localparam logic [7:0] DEF = 8'h9D;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       reg_rst = 1'b0;
  logic       tick_1s = 1'b0;
  logic [7:0] ctrl_q;
  logic       wdt_expired;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  host_wdt_reg #(.TICK_UNIT(UNIT)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .reg_rst(reg_rst), .tick_1s(tick_1s), .ctrl_q(ctrl_q),
    .wdt_expired(wdt_expired)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle from a falling edge, return at the next falling edge
  task automatic cyc(input bit t, input bit w, input logic [7:0] d, input bit r);
    tick_1s = t; wr_en = w; wr_data = d; reg_rst = r;
    @(negedge clk);
    tick_1s = 0; wr_en = 0; wr_data = '0; reg_rst = 0;
  endtask

  // n ticks separated by gap idle cycles; only the last may fire
  task automatic ticks(input int n, input int gap, input bit fires, input string req);
    for (int i = 1; i <= n; i++) begin
      cyc(1, 0, 8'h00, 0);
      if (i < n || !fires) begin
        check(req, wdt_expired, 0);
        for (int g = 0; g < gap; g++) begin
          cyc(0, 0, 8'h00, 0);
          check({req, " R3 idle"}, wdt_expired, 0);
        end
      end else begin
        check({req, " pulse"}, wdt_expired, 1);
        check("R7 defaults", ctrl_q, DEF);
      end
    end
  endtask

  function automatic int period(input int k);
    return UNIT << (k - 1);
  endfunction

  initial begin
    logic [7:0] v;
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset value", ctrl_q, DEF);
    check("R1 no pulse", wdt_expired, 0);

    // R2/R3/R6/R7/R10 sweep over select and tick gap
    for (int k = 1; k <= 3; k++) begin
      for (int gap = 0; gap <= 2; gap++) begin
        v = 8'h42 | 8'(k << 4);
        cyc(0, 1, v, 0);
        check("R6 kick visible", ctrl_q, v);
        cyc(0, 0, 8'h00, 0);
        check("R10 stored, R6 cleared", ctrl_q, v & 8'hBF);
        ticks(period(k), gap, 1, "R2");
        cyc(0, 0, 8'h00, 0);
        check("R7 one cycle", wdt_expired, 0);
      end
    end

    // R7: count restarted after expiry, default select 1
    ticks(period(1), 0, 1, "R7 restart");
    cyc(0, 0, 8'h00, 0);

    // R4: disabled select never fires
    cyc(0, 1, 8'h82, 0);
    ticks(4 * period(3), 1, 0, "R4");
    check("R4 unchanged", ctrl_q, 8'h82);

    // R5: same-value rewrite does not restart
    cyc(0, 1, 8'h60, 0);
    ticks(4, 0, 0, "R5 pre");
    cyc(0, 1, 8'h20, 0);
    ticks(2, 0, 1, "R5 same value");
    cyc(0, 0, 8'h00, 0);

    // R5: changed select restarts with the new period
    cyc(0, 1, 8'h60, 0);
    ticks(4, 0, 0, "R5 pre");
    cyc(0, 1, 8'h30, 0);
    ticks(period(3), 0, 1, "R5 changed");
    cyc(0, 0, 8'h00, 0);

    // R6: kick restarts
    ticks(2, 0, 0, "R6 pre");
    cyc(0, 1, 8'h50, 0);
    ticks(period(1), 0, 1, "R6 after kick");
    cyc(0, 0, 8'h00, 0);

    // R8: register reset clears count and register, no pulse, beats write
    cyc(0, 1, 8'h12, 0);
    ticks(2, 0, 0, "R8 pre");
    cyc(0, 1, 8'h55, 1);
    check("R8 defaults", ctrl_q, DEF);
    check("R8 no pulse", wdt_expired, 0);
    ticks(period(1), 0, 1, "R8 count cleared");
    cyc(0, 0, 8'h00, 0);

    // R9: kick on the expiring tick wins
    ticks(2, 0, 0, "R9 pre");
    cyc(1, 1, 8'h5C, 0);
    check("R9 kick beats expiry", wdt_expired, 0);
    check("R9 write stored", ctrl_q, 8'h5C);
    ticks(period(1), 0, 1, "R9 after kick");
    cyc(0, 0, 8'h00, 0);

    // R9: plain write on the expiring tick is lost
    ticks(2, 0, 0, "R9 pre");
    cyc(1, 1, 8'h10, 0);
    check("R9 expiry beats plain write", wdt_expired, 1);
    check("R9 defaults", ctrl_q, DEF);
    cyc(0, 0, 8'h00, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule